// File: doc/BRIEF.md
# Endpoint-Zero Control Transfer Sequencer

This block runs the control pipe of a USB device once a setup packet has been captured. A neighbouring capture unit raises a pending flag and presents the eight setup bytes as one 64-bit word. While that flag stays high, the sequencer keeps taking the word it is offered, so only the newest packet is acted upon.

When the flag drops, the sequencer decodes the direction, type, request and length fields. It then takes one of three paths: it stalls the request, it arms a zero-length device status packet, or it streams a response to the host. A response goes out in packets of at most `MAX_PKT` bytes. The block issues single-cycle commands to the endpoint-zero FIFOs (load, enable, clear) and a stall command. It also tracks whether the device is configured, which a standard set-configuration request changes in place.

The surrounding logic supplies the response byte count. It also reports transmit and receive acknowledges and stall handshakes. The sequencer decides on each acknowledge whether to send another packet, send a zero-length terminator, or arm the receive side for the host's status packet.

Top module: `ep0_ctrl_seq`

## Requirements
- R1: After reset every command output is 0, `stage` is 0 (idle), `configured` is 0 and `tx_len` is 0.
- R2: While `setup_pending` is high the block takes `setup_word` each cycle and returns `stage` to idle. Acknowledges in those cycles are ignored. When the flag falls, the last word taken is decoded, and its commands appear one cycle later.
- R3: A setup word whose type field (bits 6:5) equals 3 is unparseable: the block pulses `ep_stall` alone and stays idle.
- R4: A host-to-device request (bit 7 = 0) whose length field (bits 63:48) is nonzero is stalled: `ep_stall` pulses alone and the stage stays idle.
- R5: A host-to-device request with zero length pulses `tx_clr` and `tx_en` together and moves to stage 3 (awaiting device status). A transmit acknowledge or stall there returns to idle.
- R6: A standard request (type 0) with request code 9 (bits 15:8) and a nonzero value low byte (bits 23:16) sets `configured`, but only while `dev_addressed` is 1. A zero value clears it. `configured` also clears whenever `dev_addressed` is 0.
- R7: A device-to-host request (bit 7 = 1) sets the transfer total to the smaller of `resp_len` and the length field. It pulses `tx_load` with `tx_en`, with `tx_len` equal to the smaller of the total and `MAX_PKT`, and enters stage 1.
- R8: Each transmit acknowledge in stage 1 adds the last packet's size to the bytes sent. If the stage is not over, the next packet is loaded with size min(remaining, `MAX_PKT`).
- R9: The data stage ends on the acknowledge where the bytes sent equal the total, and either the total equals the length field or the last packet was shorter than `MAX_PKT`. Otherwise a zero-length packet (`tx_len` = 0) is loaded.
- R10: The end of the data stage pulses `rx_clr` with `rx_en` and moves to stage 2. A receive acknowledge or receive stall there returns to idle with no command.
- R11: A receive acknowledge in stage 3 is unexpected. The block pulses `rx_clr` with `ep_stall` and goes idle.
- R12: A transmit stall in stage 1 or 3 returns to idle with no command output.
- R13: `tx_len` keeps the size of the last loaded packet until that packet is acknowledged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| setup_pending | input | 1 | A captured setup packet is waiting |
| setup_word | input | 64 | Setup bytes, byte 0 in bits 7:0 |
| resp_len | input | 16 | Bytes the device has ready for a device-to-host request |
| dev_addressed | input | 1 | The device holds a bus address |
| tx_ack | input | 1 | Transmit packet acknowledged by host |
| tx_stall | input | 1 | Transmit transaction ended in a stall |
| rx_ack | input | 1 | Receive packet acknowledged |
| rx_stall | input | 1 | Receive transaction ended in a stall |
| tx_load | output | 1 | Load a packet of `tx_len` bytes into the transmit FIFO |
| tx_len | output | PKT_W | Size of the current transmit packet |
| tx_en | output | 1 | Enable the transmit FIFO |
| tx_clr | output | 1 | Clear the transmit FIFO |
| rx_clr | output | 1 | Clear the receive FIFO |
| rx_en | output | 1 | Enable the receive FIFO |
| ep_stall | output | 1 | Stall the next endpoint-zero transaction |
| configured | output | 1 | Device is in the configured state |
| stage | output | 2 | 0 idle, 1 data, 2 awaiting host status, 3 awaiting device status |

## Verification
A new setup packet and a transmit acknowledge for the packet in flight can arrive in the same cycle. The bench provokes this by raising `setup_pending` and `tx_ack` on the same edge while a response is halfway through. It judges the result through the scoreboard: the only commands that may follow are the first packet of the new request, and no follow-on packet from the abandoned one. A second coincidence is also exercised: a repeated setup flag carrying two different words, where only the later word's response may appear.

// File: rtl/ep0_seq_pkg.sv
package ep0_seq_pkg;
    localparam int LEN_W = 16;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_DATA  = 2'd1,
        ST_HSTAT = 2'd2,
        ST_DSTAT = 2'd3
    } stage_e;

    typedef struct packed {
        logic tx_load;
        logic tx_en;
        logic tx_clr;
        logic rx_clr;
        logic rx_en;
        logic stall;
    } cmd_t;

    localparam logic [7:0] REQ_SET_CFG = 8'd9;
endpackage

// File: rtl/ep0_setup_decode.sv
module ep0_setup_decode
    import ep0_seq_pkg::*;
(
    input  logic [63:0]      word_i,
    output logic             dir_in_o,
    output logic             bad_o,
    output logic [LEN_W-1:0] wlen_o,
    output logic             set_cfg_o,
    output logic             cfg_nz_o
);
    logic [1:0] req_type;

    always_comb begin
        req_type  = word_i[6:5];
        dir_in_o  = word_i[7];
        bad_o     = (req_type == 2'b11);
        wlen_o    = word_i[63:48];
        set_cfg_o = (req_type == 2'b00) && (word_i[15:8] == REQ_SET_CFG);
        cfg_nz_o  = (word_i[23:16] != 8'd0);
    end
endmodule

// File: rtl/ep0_pkt_sizer.sv
module ep0_pkt_sizer
    import ep0_seq_pkg::*;
#(
    parameter int MAX_PKT = 64,
    parameter int PKT_W   = $clog2(MAX_PKT + 1)
) (
    input  logic [LEN_W-1:0] total_i,
    input  logic [LEN_W-1:0] sent_i,
    input  logic [LEN_W-1:0] wlen_i,
    input  logic [PKT_W-1:0] last_i,
    output logic [PKT_W-1:0] pkt_o,
    output logic             done_o
);
    localparam logic [LEN_W-1:0] MPS_L = LEN_W'(MAX_PKT);
    localparam logic [PKT_W-1:0] MPS_P = PKT_W'(MAX_PKT);

    logic [LEN_W-1:0] remain;

    always_comb begin
        remain = total_i - sent_i;
        pkt_o  = (remain > MPS_L) ? MPS_P : PKT_W'(remain);
        done_o = (sent_i == total_i) &&
                 ((total_i == wlen_i) || (last_i != MPS_P));
    end
endmodule

// File: rtl/ep0_ctrl_seq.sv
module ep0_ctrl_seq
    import ep0_seq_pkg::*;
#(
    parameter int MAX_PKT = 64,
    localparam int PKT_W  = $clog2(MAX_PKT + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             setup_pending,
    input  logic [63:0]      setup_word,
    input  logic [15:0]      resp_len,
    input  logic             dev_addressed,
    input  logic             tx_ack,
    input  logic             tx_stall,
    input  logic             rx_ack,
    input  logic             rx_stall,
    output logic             tx_load,
    output logic [PKT_W-1:0] tx_len,
    output logic             tx_en,
    output logic             tx_clr,
    output logic             rx_clr,
    output logic             rx_en,
    output logic             ep_stall,
    output logic             configured,
    output logic [1:0]       stage
);
    typedef struct packed {
        stage_e           stage;
        logic             cfgd;
        logic             got;
        logic [63:0]      setup;
        logic [LEN_W-1:0] total;
        logic [LEN_W-1:0] wlen;
        logic [LEN_W-1:0] sent;
        logic [PKT_W-1:0] last;
        cmd_t             cmd;
    } regs_t;

    regs_t q, d;

    logic             dec_in, dec_bad, dec_setcfg, dec_cfgnz;
    logic [LEN_W-1:0] dec_wlen, clamp_len;
    logic [LEN_W-1:0] sz_total, sz_sent, sz_wlen;
    logic [PKT_W-1:0] sz_pkt;
    logic             sz_done;

    ep0_setup_decode u_dec (
        .word_i    (q.setup),
        .dir_in_o  (dec_in),
        .bad_o     (dec_bad),
        .wlen_o    (dec_wlen),
        .set_cfg_o (dec_setcfg),
        .cfg_nz_o  (dec_cfgnz)
    );

    always_comb begin
        clamp_len = (resp_len > dec_wlen) ? dec_wlen : resp_len;
        if (q.stage == ST_DATA) begin
            sz_total = q.total;
            sz_sent  = q.sent + LEN_W'(q.last);
            sz_wlen  = q.wlen;
        end else begin
            sz_total = clamp_len;
            sz_sent  = '0;
            sz_wlen  = dec_wlen;
        end
    end

    ep0_pkt_sizer #(.MAX_PKT(MAX_PKT), .PKT_W(PKT_W)) u_size (
        .total_i (sz_total),
        .sent_i  (sz_sent),
        .wlen_i  (sz_wlen),
        .last_i  (q.last),
        .pkt_o   (sz_pkt),
        .done_o  (sz_done)
    );

    always_comb begin
        d     = q;
        d.cmd = '0;
        if (setup_pending) begin
            d.got   = 1'b1;
            d.setup = setup_word;
            d.stage = ST_IDLE;
        end else if (q.got) begin
            d.got = 1'b0;
            if (dec_bad) begin
                d.cmd.stall = 1'b1;
            end else if (!dec_in) begin
                if (dec_wlen != '0) begin
                    d.cmd.stall = 1'b1;
                end else begin
                    if (dec_setcfg) begin
                        if (dec_cfgnz && dev_addressed && !q.cfgd) begin
                            d.cfgd = 1'b1;
                        end else if (!dec_cfgnz && q.cfgd) begin
                            d.cfgd = 1'b0;
                        end
                    end
                    d.cmd.tx_clr = 1'b1;
                    d.cmd.tx_en  = 1'b1;
                    d.stage      = ST_DSTAT;
                end
            end else begin
                d.total       = clamp_len;
                d.wlen        = dec_wlen;
                d.sent        = '0;
                d.last        = sz_pkt;
                d.cmd.tx_load = 1'b1;
                d.cmd.tx_en   = 1'b1;
                d.stage       = ST_DATA;
            end
        end else begin
            unique case (q.stage)
                ST_DATA: begin
                    if (tx_stall) begin
                        d.stage = ST_IDLE;
                    end else if (tx_ack) begin
                        d.sent = sz_sent;
                        if (sz_done) begin
                            d.cmd.rx_clr = 1'b1;
                            d.cmd.rx_en  = 1'b1;
                            d.stage      = ST_HSTAT;
                        end else begin
                            d.last        = sz_pkt;
                            d.cmd.tx_load = 1'b1;
                            d.cmd.tx_en   = 1'b1;
                        end
                    end
                end
                ST_HSTAT: begin
                    if (rx_ack || rx_stall) begin
                        d.stage = ST_IDLE;
                    end
                end
                ST_DSTAT: begin
                    if (tx_stall || rx_stall) begin
                        d.stage = ST_IDLE;
                    end else if (rx_ack) begin
                        d.cmd.rx_clr = 1'b1;
                        d.cmd.stall  = 1'b1;
                        d.stage      = ST_IDLE;
                    end else if (tx_ack) begin
                        d.stage = ST_IDLE;
                    end
                end
                default: d.stage = ST_IDLE;
            endcase
        end
        if (!dev_addressed) begin
            d.cfgd = 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q <= '0;
        end else begin
            q <= d;
        end
    end

    assign tx_load    = q.cmd.tx_load;
    assign tx_en      = q.cmd.tx_en;
    assign tx_clr     = q.cmd.tx_clr;
    assign rx_clr     = q.cmd.rx_clr;
    assign rx_en      = q.cmd.rx_en;
    assign ep_stall   = q.cmd.stall;
    assign tx_len     = q.last;
    assign configured = q.cfgd;
    assign stage      = q.stage;
endmodule

// File: rtl/ep0_ctrl_seq_chk.sv
module ep0_ctrl_seq_chk #(
    parameter int MAX_PKT = 64,
    parameter int PKT_W   = 7
) (
    input logic             clk,
    input logic             rst_n,
    input logic             setup_pending,
    input logic             dev_addressed,
    input logic             tx_ack,
    input logic             tx_stall,
    input logic             tx_load,
    input logic [PKT_W-1:0] tx_len,
    input logic             tx_en,
    input logic             rx_clr,
    input logic             rx_en,
    input logic             ep_stall,
    input logic             configured,
    input logic [1:0]       stage
);
    // R7
    load_en_chk: assert property (@(posedge clk) disable iff (!rst_n)
        tx_load |-> (tx_en && !ep_stall && stage == 2'd1));

    // R8
    pkt_max_chk: assert property (@(posedge clk) disable iff (!rst_n)
        tx_load |-> (int'(tx_len) <= MAX_PKT));

    // R6
    cfg_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(configured) |-> $past(dev_addressed));

    // R10
    rx_arm_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rx_en |-> (rx_clr && stage == 2'd2));

    // R11
    stall_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ep_stall |-> (stage == 2'd0 && !tx_en));

    // R12
    tx_stall_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (stage == 2'd1 && tx_stall) |=> (stage == 2'd0 && !tx_load));

    // R13
    len_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (stage == 2'd1 && !tx_ack && !setup_pending) |=> $stable(tx_len));
endmodule

bind ep0_ctrl_seq ep0_ctrl_seq_chk #(.MAX_PKT(MAX_PKT), .PKT_W(PKT_W)) u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .setup_pending (setup_pending),
    .dev_addressed (dev_addressed),
    .tx_ack        (tx_ack),
    .tx_stall      (tx_stall),
    .tx_load       (tx_load),
    .tx_len        (tx_len),
    .tx_en         (tx_en),
    .rx_clr        (rx_clr),
    .rx_en         (rx_en),
    .ep_stall      (ep_stall),
    .configured    (configured),
    .stage         (stage)
);

// File: tb/tb_ep0_ctrl_seq.sv
module tb_ep0_ctrl_seq;
    localparam int CLK_PERIOD = 10;
    localparam int MPS = 8;
    localparam int PW  = $clog2(MPS + 1);

    localparam logic [5:0] C_LOAD  = 6'b110000;
    localparam logic [5:0] C_WST   = 6'b011000;
    localparam logic [5:0] C_RXARM = 6'b000110;
    localparam logic [5:0] C_RXSTL = 6'b000101;
    localparam logic [5:0] C_STALL = 6'b000001;

    logic clk = 0, rst_n = 0;
    logic setup_pending = 0, dev_addressed = 1;
    logic [63:0] setup_word = '0;
    logic [15:0] resp_len = '0;
    logic tx_ack = 0, tx_stall = 0, rx_ack = 0, rx_stall = 0;
    logic tx_load, tx_en, tx_clr, rx_clr, rx_en, ep_stall, configured;
    logic [PW-1:0] tx_len;
    logic [1:0] stage;

    int nchk = 0, nfail = 0;
    bit finished = 0;
    logic [PW+5:0] exp_q[$];
    string tag_q[$];

    always #(CLK_PERIOD/2) clk = ~clk;

    ep0_ctrl_seq #(.MAX_PKT(MPS)) dut (
        .clk(clk), .rst_n(rst_n), .setup_pending(setup_pending),
        .setup_word(setup_word), .resp_len(resp_len),
        .dev_addressed(dev_addressed), .tx_ack(tx_ack), .tx_stall(tx_stall),
        .rx_ack(rx_ack), .rx_stall(rx_stall), .tx_load(tx_load),
        .tx_len(tx_len), .tx_en(tx_en), .tx_clr(tx_clr), .rx_clr(rx_clr),
        .rx_en(rx_en), .ep_stall(ep_stall), .configured(configured),
        .stage(stage)
    );

    task automatic check(input bit ok, input string req, input string what,
                         input int act, input int exp);
        nchk++;
        if (!ok) begin
            nfail++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic expect_cmd(input logic [5:0] c, input int len, input string t);
        exp_q.push_back({c, PW'(len)});
        tag_q.push_back(t);
    endtask

    // monitor: pops one expected item per cycle that shows any command
    logic [5:0]    mon_s;
    logic [PW+5:0] mon_e;
    string         mon_t;
    always @(negedge clk) begin
        if (rst_n) begin
            mon_s = {tx_load, tx_en, tx_clr, rx_clr, rx_en, ep_stall};
            if (mon_s != 6'b0) begin
                if (exp_q.size() == 0) begin
                    check(0, "R2", "unexpected command", int'(mon_s), 0);
                end else begin
                    mon_e = exp_q.pop_front();
                    mon_t = tag_q.pop_front();
                    check(mon_s == mon_e[PW+5:PW] &&
                          (!tx_load || tx_len == mon_e[PW-1:0]),
                          mon_t, "command", int'({mon_s, tx_len}), int'(mon_e));
                end
            end
        end
    end

    function automatic logic [63:0] mk(input logic [7:0] rt, input logic [7:0] rq,
                                       input logic [15:0] val, input logic [15:0] wl);
        return {wl, 16'h0000, val, rq, rt};
    endfunction

    task automatic send_setup(input logic [63:0] w, input logic [15:0] r);
        @(negedge clk);
        setup_pending = 1; setup_word = w; resp_len = r;
        @(negedge clk);
        setup_pending = 0;
        @(negedge clk);
    endtask

    task automatic pulse_tx_ack();
        @(negedge clk); tx_ack = 1;
        @(negedge clk); tx_ack = 0;
    endtask

    task automatic pulse_rx_ack();
        @(negedge clk); rx_ack = 1;
        @(negedge clk); rx_ack = 0;
    endtask

    task automatic chk_stage(input int s, input string req);
        check(int'(stage) == s, req, "stage", int'(stage), s);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        // R1 reset state
        check({tx_load, tx_en, tx_clr, rx_clr, rx_en, ep_stall} == 6'b0, "R1", "commands", 0, 0);
        chk_stage(0, "R1");
        check(configured == 0 && tx_len == 0, "R1", "cfg/len", int'(configured), 0);
        rst_n = 1;

        // R7/R8/R10: 20 bytes of 64 requested -> 8,8,4 then status
        expect_cmd(C_LOAD, 8, "R7");
        send_setup(mk(8'h80, 8'h06, 16'h0100, 16'd64), 16'd20);
        chk_stage(1, "R7");
        repeat (3) @(negedge clk);
        check(tx_len == 8, "R13", "held length", int'(tx_len), 8);
        expect_cmd(C_LOAD, 8, "R8");
        pulse_tx_ack();
        expect_cmd(C_LOAD, 4, "R8");
        pulse_tx_ack();
        expect_cmd(C_RXARM, 0, "R10");
        pulse_tx_ack();
        chk_stage(2, "R10");
        pulse_rx_ack();
        chk_stage(0, "R10");

        // R9: 16 of 64, last full -> zero-length terminator
        expect_cmd(C_LOAD, 8, "R9");
        send_setup(mk(8'h80, 8'h06, 16'h0200, 16'd64), 16'd16);
        expect_cmd(C_LOAD, 8, "R9");
        pulse_tx_ack();
        expect_cmd(C_LOAD, 0, "R9");
        pulse_tx_ack();
        expect_cmd(C_RXARM, 0, "R9");
        pulse_tx_ack();
        chk_stage(2, "R9");
        @(negedge clk); rx_stall = 1; @(negedge clk); rx_stall = 0;
        chk_stage(0, "R10");

        // R9: 16 of 16 -> no terminator
        expect_cmd(C_LOAD, 8, "R9");
        send_setup(mk(8'h80, 8'h06, 16'h0200, 16'd16), 16'd16);
        expect_cmd(C_LOAD, 8, "R9");
        pulse_tx_ack();
        expect_cmd(C_RXARM, 0, "R9");
        pulse_tx_ack();
        chk_stage(2, "R9");
        pulse_rx_ack();

        // R7: response longer than requested is clamped (100 vs 10)
        expect_cmd(C_LOAD, 8, "R7");
        send_setup(mk(8'h80, 8'h06, 16'h0300, 16'd10), 16'd100);
        expect_cmd(C_LOAD, 2, "R7");
        pulse_tx_ack();
        // R12 transmit stall mid-stage
        @(negedge clk); tx_stall = 1; @(negedge clk); tx_stall = 0;
        chk_stage(0, "R12");

        // R6: set configuration 1 while addressed
        expect_cmd(C_WST, 0, "R5");
        send_setup(mk(8'h00, 8'h09, 16'h0001, 16'd0), 16'd0);
        chk_stage(3, "R5");
        check(configured == 1, "R6", "configured set", int'(configured), 1);
        pulse_tx_ack();
        chk_stage(0, "R5");
        // R6: set configuration 0
        expect_cmd(C_WST, 0, "R6");
        send_setup(mk(8'h00, 8'h09, 16'h0000, 16'd0), 16'd0);
        check(configured == 0, "R6", "configured cleared", int'(configured), 0);
        pulse_tx_ack();
        // R6: not addressed -> ignored
        dev_addressed = 0;
        expect_cmd(C_WST, 0, "R6");
        send_setup(mk(8'h00, 8'h09, 16'h0002, 16'd0), 16'd0);
        check(configured == 0, "R6", "ignored when unaddressed", int'(configured), 0);
        pulse_tx_ack();
        dev_addressed = 1;
        expect_cmd(C_WST, 0, "R6");
        send_setup(mk(8'h00, 8'h09, 16'h0003, 16'd0), 16'd0);
        check(configured == 1, "R6", "configured again", int'(configured), 1);
        // R11 unexpected receive ack in device status stage
        expect_cmd(C_RXSTL, 0, "R11");
        pulse_rx_ack();
        chk_stage(0, "R11");
        // R6 address loss clears configured
        @(negedge clk); dev_addressed = 0;
        @(negedge clk); @(negedge clk);
        check(configured == 0, "R6", "cleared on address loss", int'(configured), 0);
        dev_addressed = 1;

        // R4 host-to-device with data stage -> stall
        expect_cmd(C_STALL, 0, "R4");
        send_setup(mk(8'h00, 8'h07, 16'h0000, 16'd4), 16'd0);
        chk_stage(0, "R4");
        // R3 unparseable type
        expect_cmd(C_STALL, 0, "R3");
        send_setup(mk(8'hE0, 8'h01, 16'h0000, 16'd8), 16'd8);
        chk_stage(0, "R3");

        // R2 repeated setup: newest word wins
        expect_cmd(C_LOAD, 3, "R2");
        @(negedge clk);
        setup_pending = 1; setup_word = mk(8'h00, 8'h09, 16'h0001, 16'd0);
        @(negedge clk);
        setup_word = mk(8'h80, 8'h06, 16'h0100, 16'd3); resp_len = 16'd3;
        @(negedge clk);
        setup_pending = 0;
        @(negedge clk);
        chk_stage(1, "R2");

        // R2 collision: new setup and tx ack on the same edge
        expect_cmd(C_LOAD, 5, "R2");
        @(negedge clk);
        tx_ack = 1; setup_pending = 1;
        setup_word = mk(8'h80, 8'h06, 16'h0100, 16'd5); resp_len = 16'd5;
        @(negedge clk);
        tx_ack = 0; setup_pending = 0;
        @(negedge clk);
        chk_stage(1, "R2");
        expect_cmd(C_RXARM, 0, "R10");
        pulse_tx_ack();
        pulse_rx_ack();
        chk_stage(0, "R10");

        repeat (3) @(negedge clk);
        check(exp_q.size() == 0, "R2", "missing commands", exp_q.size(), 0);
        finished = 1;
        $display("%0d/%0d checks passed", nchk - nfail, nchk);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            check(0, "R1", "watchdog expired", 0, 1);
            $display("%0d/%0d checks passed", nchk - nfail, nchk);
            $finish;
        end
    end
endmodule